// File: doc/BRIEF.md
# CAN Receive Mailbox Move-In Unit

This unit holds a bank of CAN receive message buffers and moves each accepted frame from an upstream bit-level receiver into one of them. For every incoming frame, the receiver supplies the identifier, the SRR, IDE and RTR flags, the length code, up to eight data bytes and a completion pulse. Before that, while the frame is still arriving, it sends a separate strobe on the second identifier bit. The unit looks for a buffer whose state code is EMPTY or FULL and whose stored 29-bit identifier matches exactly. It writes the frame into that buffer over several cycles and stamps it with the free-running timer value latched at the strobe. It then updates the buffer's state code and raises the buffer's flag bit. A per-buffer mask gates the interrupt lines.

A simple register port gives the CPU access to each buffer's four words and to the flag and mask registers. A buffer's control/status word carries a lock bit that stays set while a move-in into that buffer is in progress. Software re-reads the word until the lock bit clears and only then reads the frame. To arm a buffer, software first writes its identifier and then writes the EMPTY code.

Top module: `can_rx_mailbox_unit`

## Requirements
- R1: After reset every buffer's state code reads 4'b0000 (inactive), the flag register and the mask register read zero, and all interrupt lines are low.
- R2: A frame is accepted only by a buffer whose state code is EMPTY (4'b0100) or FULL (4'b0010) and whose 29-bit identifier equals the frame's identifier. If no buffer qualifies, the frame is dropped and no buffer, flag or interrupt changes.
- R3: When several buffers qualify, the lowest-numbered one receives the frame.
- R4: Data bytes are stored with frame data bits 31:0 in word 2 and bits 63:32 in word 3 of the buffer.
- R5: The frame identifier is stored in bits 28:0 of word 1; bits 31:29 of word 1 read zero.
- R6: The time stamp in bits 31:16 of word 0 equals the timer value latched in the cycle the second-identifier-bit strobe is high. The timer clears on reset and advances by one every clock.
- R7: The received flags and length are stored in word 0: length code in bits 3:0, RTR in bit 4, IDE in bit 5, SRR in bit 6.
- R8: The state code is held in bits 11:8 of word 0. Move-in sets it to FULL if the buffer was EMPTY and to OVERRUN (4'b0110) if the buffer was already FULL.
- R9: The buffer's flag bit is set one cycle after its state code is updated. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: Interrupt line i is a registered copy of (flag bit i AND mask bit i). It is never high unless its mask bit was set.
- R11: Bit 7 of word 0 (lock) reads 1 from the cycle after the frame is accepted until the state code is updated, and reads 0 afterwards.
- R12: CPU address bit [MB_W+2] = 0 selects buffer space, with the buffer number in bits [MB_W+1:2] and the word number in bits [1:0]. Bit [MB_W+2] = 1 selects the flag register (bit 0 = 0) or the mask register (bit 0 = 1). Read data is valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_idb2_stb | input | 1 | Pulse on the second identifier bit of the frame in flight |
| rx_frame_vld | input | 1 | One-cycle pulse: a complete frame is presented |
| rx_id | input | 29 | Received identifier |
| rx_srr | input | 1 | Received SRR bit |
| rx_ide | input | 1 | Received IDE bit |
| rx_rtr | input | 1 | Received RTR bit |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data bytes |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | MB_W+3 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, one cycle after cpu_rd |
| irq_o | output | NUM_MB | Masked per-buffer interrupt lines |

## Verification
The bench builds the unit with eight buffers and a 16-bit time stamp. With eight buffers and a pool of only six identifiers, random configuration regularly leaves several armed buffers sharing one identifier. That exercises the lowest-index priority, the EMPTY-to-FULL-to-OVERRUN progression and dropped frames many times in a short run. The narrow buffer field also keeps a full readback of every buffer after each frame cheap, so a write that lands in the wrong buffer is caught.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  localparam int CAN_ID_W = 29;

  localparam logic [3:0] MB_INACTIVE = 4'b0000;
  localparam logic [3:0] MB_FULL     = 4'b0010;
  localparam logic [3:0] MB_EMPTY    = 4'b0100;
  localparam logic [3:0] MB_OVERRUN  = 4'b0110;

  localparam logic [1:0] WORD_CS = 2'd0;
  localparam logic [1:0] WORD_ID = 2'd1;
  localparam logic [1:0] WORD_D0 = 2'd2;
  localparam logic [1:0] WORD_D1 = 2'd3;

  typedef enum logic [2:0] {
    MV_IDLE,
    MV_DATA0,
    MV_DATA1,
    MV_CTRL,
    MV_FLAG
  } mv_state_e;
endpackage

// File: rtl/can_mbx_match.sv
module can_mbx_match
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int MB_W   = 4
) (
  input  logic [NUM_MB*4-1:0]        code_flat,
  input  logic [NUM_MB*CAN_ID_W-1:0] id_flat,
  input  logic [CAN_ID_W-1:0]        rx_id,
  output logic                       hit,
  output logic [MB_W-1:0]            idx
);
  logic [NUM_MB-1:0] elig;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_cmp
    logic [3:0] c;
    assign c = code_flat[g*4 +: 4];
    assign elig[g] = ((c == MB_EMPTY) || (c == MB_FULL)) &&
                     (id_flat[g*CAN_ID_W +: CAN_ID_W] == rx_id);
  end

  // Scan from the top so the lowest index is written last and wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = MB_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_mbx_ram.sv
module can_mbx_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_mbx_irq.sv
module can_mbx_irq #(
  parameter int NUM_MB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] set_vec,
  input  logic              wr_flag,
  input  logic              wr_mask,
  input  logic [NUM_MB-1:0] wdata,
  output logic [NUM_MB-1:0] iflag,
  output logic [NUM_MB-1:0] imask,
  output logic [NUM_MB-1:0] irq
);
  logic [NUM_MB-1:0] clr_vec;
  assign clr_vec = wr_flag ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      iflag <= '0;
      imask <= '0;
      irq   <= '0;
    end else begin
      iflag <= (iflag & ~clr_vec) | set_vec;
      if (wr_mask) imask <= wdata;
      irq <= iflag & imask;
    end
  end
endmodule

// File: rtl/can_rx_mailbox_unit.sv
module can_rx_mailbox_unit
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int TS_W   = 16,
  localparam int MB_W  = $clog2(NUM_MB),
  localparam int AW    = MB_W + 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_idb2_stb,
  input  logic                rx_frame_vld,
  input  logic [28:0]         rx_id,
  input  logic                rx_srr,
  input  logic                rx_ide,
  input  logic                rx_rtr,
  input  logic [3:0]          rx_dlc,
  input  logic [63:0]         rx_data,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [31:0]         cpu_wdata,
  output logic [31:0]         cpu_rdata,
  output logic [NUM_MB-1:0]   irq_o
);
  localparam int RAM_AW    = MB_W + 2;
  localparam int RAM_DEPTH = NUM_MB * 4;

  // ---------------- timer and stamp latch ----------------
  logic [TS_W-1:0] tmr_q, ts_lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q    <= '0;
      ts_lat_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
      if (rx_idb2_stb) ts_lat_q <= tmr_q;
    end
  end

  // ---------------- CPU decode ----------------
  logic            cpu_is_reg;
  logic [MB_W-1:0] cpu_mb;
  logic [1:0]      cpu_word;
  logic            cpu_mb_wr;

  assign cpu_is_reg = cpu_addr[AW-1];
  assign cpu_mb     = cpu_addr[MB_W+1:2];
  assign cpu_word   = cpu_addr[1:0];
  assign cpu_mb_wr  = cpu_wr && !cpu_is_reg;

  // ---------------- per-buffer code and identifier ----------------
  logic [3:0]          code_q [NUM_MB];
  logic [CAN_ID_W-1:0] id_q   [NUM_MB];
  logic [NUM_MB*4-1:0]        code_flat;
  logic [NUM_MB*CAN_ID_W-1:0] id_flat;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_flat
    assign code_flat[g*4 +: 4]               = code_q[g];
    assign id_flat[g*CAN_ID_W +: CAN_ID_W]   = id_q[g];
  end

  logic            m_hit;
  logic [MB_W-1:0] m_idx;

  can_mbx_match #(.NUM_MB(NUM_MB), .MB_W(MB_W)) match_i (
    .code_flat (code_flat),
    .id_flat   (id_flat),
    .rx_id     (rx_id),
    .hit       (m_hit),
    .idx       (m_idx)
  );

  // ---------------- move-in sequencer ----------------
  mv_state_e           state_q;
  logic [MB_W-1:0]     mb_q;
  logic                busy_q;
  logic                f_ovr_q;
  logic [CAN_ID_W-1:0] f_id_q;
  logic [6:0]          f_ctrl_q;
  logic [63:0]         f_data_q;
  logic [TS_W-1:0]     f_ts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= MV_IDLE;
      mb_q     <= '0;
      busy_q   <= 1'b0;
      f_ovr_q  <= 1'b0;
      f_id_q   <= '0;
      f_ctrl_q <= '0;
      f_data_q <= '0;
      f_ts_q   <= '0;
    end else begin
      unique case (state_q)
        MV_IDLE: begin
          if (rx_frame_vld && m_hit) begin
            state_q  <= MV_DATA0;
            mb_q     <= m_idx;
            busy_q   <= 1'b1;
            f_ovr_q  <= (code_q[m_idx] == MB_FULL);
            f_id_q   <= rx_id;
            f_ctrl_q <= {rx_srr, rx_ide, rx_rtr, rx_dlc};
            f_data_q <= rx_data;
            f_ts_q   <= ts_lat_q;
          end
        end
        MV_DATA0: state_q <= MV_DATA1;
        MV_DATA1: state_q <= MV_CTRL;
        MV_CTRL: begin
          state_q <= MV_FLAG;
          busy_q  <= 1'b0;
        end
        MV_FLAG: state_q <= MV_IDLE;
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  // Code/identifier registers: CPU writes first, sequencer last so it wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MB; i++) begin
        code_q[i] <= MB_INACTIVE;
        id_q[i]   <= '0;
      end
    end else begin
      if (cpu_mb_wr && cpu_word == WORD_CS) code_q[cpu_mb] <= cpu_wdata[11:8];
      if (cpu_mb_wr && cpu_word == WORD_ID) id_q[cpu_mb]   <= cpu_wdata[CAN_ID_W-1:0];
      if (state_q == MV_CTRL) begin
        code_q[mb_q] <= f_ovr_q ? MB_OVERRUN : MB_FULL;
        id_q[mb_q]   <= f_id_q;
      end
    end
  end

  // ---------------- buffer word RAM ----------------
  logic              ram_we;
  logic [RAM_AW-1:0] ram_wa;
  logic [31:0]       ram_wd;
  logic [31:0]       ram_rd;
  logic [15:0]       ts16;

  assign ts16 = 16'(f_ts_q);

  always_comb begin
    ram_we = 1'b0;
    ram_wa = {mb_q, WORD_CS};
    ram_wd = '0;
    unique case (state_q)
      MV_DATA0: begin
        ram_we = 1'b1;
        ram_wa = {mb_q, WORD_D0};
        ram_wd = f_data_q[31:0];
      end
      MV_DATA1: begin
        ram_we = 1'b1;
        ram_wa = {mb_q, WORD_D1};
        ram_wd = f_data_q[63:32];
      end
      MV_CTRL: begin
        ram_we = 1'b1;
        ram_wa = {mb_q, WORD_CS};
        ram_wd = {ts16, 9'd0, f_ctrl_q};
      end
      default: begin
        ram_we = cpu_mb_wr && (cpu_word != WORD_ID);
        ram_wa = cpu_addr[RAM_AW-1:0];
        ram_wd = cpu_wdata;
      end
    endcase
  end

  can_mbx_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW), .DW(32)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_wa),
    .wdata (ram_wd),
    .re    (cpu_rd && !cpu_is_reg),
    .raddr (cpu_addr[RAM_AW-1:0]),
    .rdata (ram_rd)
  );

  // ---------------- flags, mask, interrupts ----------------
  logic [NUM_MB-1:0] flag_set, iflag_w, imask_w;

  assign flag_set = (state_q == MV_FLAG) ? (NUM_MB'(1) << mb_q) : '0;

  can_mbx_irq #(.NUM_MB(NUM_MB)) irq_i (
    .clk     (clk),
    .rst     (rst),
    .set_vec (flag_set),
    .wr_flag (cpu_wr && cpu_is_reg && !cpu_addr[0]),
    .wr_mask (cpu_wr && cpu_is_reg &&  cpu_addr[0]),
    .wdata   (cpu_wdata[NUM_MB-1:0]),
    .iflag   (iflag_w),
    .imask   (imask_w),
    .irq     (irq_o)
  );

  // ---------------- CPU read return ----------------
  logic                rs_reg_q;
  logic [1:0]          rs_word_q;
  logic [3:0]          rs_code_q;
  logic                rs_busy_q;
  logic [CAN_ID_W-1:0] rs_id_q;
  logic [31:0]         rs_regval_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_reg_q    <= 1'b0;
      rs_word_q   <= '0;
      rs_code_q   <= '0;
      rs_busy_q   <= 1'b0;
      rs_id_q     <= '0;
      rs_regval_q <= '0;
    end else if (cpu_rd) begin
      rs_reg_q    <= cpu_is_reg;
      rs_word_q   <= cpu_word;
      rs_code_q   <= code_q[cpu_mb];
      rs_busy_q   <= busy_q && (mb_q == cpu_mb);
      rs_id_q     <= id_q[cpu_mb];
      rs_regval_q <= cpu_addr[0] ? 32'(imask_w) : 32'(iflag_w);
    end
  end

  always_comb begin
    if (rs_reg_q) begin
      cpu_rdata = rs_regval_q;
    end else begin
      unique case (rs_word_q)
        WORD_CS: cpu_rdata = {ram_rd[31:12], rs_code_q, rs_busy_q, ram_rd[6:0]};
        WORD_ID: cpu_rdata = {3'b000, rs_id_q};
        default: cpu_rdata = ram_rd;
      endcase
    end
  end
endmodule

// File: rtl/can_rx_mailbox_unit_chk.sv
module can_rx_mailbox_unit_chk
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int MB_W   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic [MB_W-1:0]     mb,
  input logic [NUM_MB*4-1:0] code_flat,
  input logic [NUM_MB-1:0]   iflag,
  input logic [NUM_MB-1:0]   imask,
  input logic [NUM_MB-1:0]   irq
);
  logic [NUM_MB*4-1:0] code_prev;

  always_ff @(posedge clk) begin
    if (rst) code_prev <= '0;
    else     code_prev <= code_flat;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq & ~$past(imask)) == '0); // R10

  AST_LOCK_SPANS_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R11

  AST_ACCEPT_ARMED_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (code_prev[mb*4 +: 4] == MB_EMPTY || code_prev[mb*4 +: 4] == MB_FULL)); // R2

  AST_CODE_AT_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (code_flat[mb*4 +: 4] == MB_FULL || code_flat[mb*4 +: 4] == MB_OVERRUN)); // R8

  AST_FLAG_AFTER_CODE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> iflag[mb]); // R9
endmodule

bind can_rx_mailbox_unit can_rx_mailbox_unit_chk #(.NUM_MB(NUM_MB), .MB_W(MB_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy_q),
  .mb        (mb_q),
  .code_flat (code_flat),
  .iflag     (iflag_w),
  .imask     (imask_w),
  .irq       (irq_o)
);

// File: tb/can_rx_mailbox_unit_tb_top.sv
`timescale 1ns/1ps
module can_rx_mailbox_unit_tb_top;
  localparam int NMB = 8;
  localparam int AW  = 6;
  localparam logic [3:0] C_INA = 4'b0000, C_FULL = 4'b0010, C_EMPTY = 4'b0100, C_OVR = 4'b0110;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_idb2_stb = 0, rx_frame_vld = 0, rx_srr = 0, rx_ide = 0, rx_rtr = 0;
  logic [28:0] rx_id = '0;
  logic [3:0] rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic [NMB-1:0] irq_o;

  always #2.5 clk = ~clk;

  can_rx_mailbox_unit #(.NUM_MB(NMB), .TS_W(16)) dut_i (.*);

  int unsigned tb_cnt;
  always @(posedge clk) tb_cnt <= rst ? 0 : tb_cnt + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0]  m_code [NMB];
  logic [28:0] m_id   [NMB];
  logic [31:0] m_cs   [NMB];
  logic [31:0] m_d0   [NMB];
  logic [31:0] m_d1   [NMB];
  bit          m_dv   [NMB];
  logic [NMB-1:0] m_iflag = '0, m_imask = '0;
  logic [28:0] pool [6] = '{29'h0000123, 29'h1ABCDEF, 29'h0000000, 29'h1FFFFFFF, 29'h00007FF, 29'h0A5A5A5};

  function automatic logic [AW-1:0] mba(int mb, int w);
    return {1'b0, 3'(mb), 2'(w)};
  endfunction
  function automatic logic [AW-1:0] rega(bit msk);
    return {1'b1, 4'b0, msk};
  endfunction
  function automatic int find_mb(logic [28:0] id);
    for (int i = 0; i < NMB; i++)
      if ((m_code[i] == C_EMPTY || m_code[i] == C_FULL) && m_id[i] == id) return i;
    return -1;
  endfunction
  function automatic logic [31:0] exp_cs(int mb);
    return {m_cs[mb][31:12], m_code[mb], 1'b0, m_cs[mb][6:0]};
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(logic [AW-1:0] a, logic [31:0] d);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0;
  endtask
  task automatic cpu_read(logic [AW-1:0] a, output logic [31:0] d);
    cpu_rd = 1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 0;
    d = cpu_rdata;
  endtask

  task automatic arm(int mb, logic [28:0] id, logic [3:0] code, logic [31:0] extra);
    logic [31:0] w;
    w = (extra & 32'hFFFF_F07F) | {20'd0, code, 8'd0};
    cpu_write(mba(mb, 1), {3'b0, id});
    cpu_write(mba(mb, 0), w);
    m_id[mb] = id; m_code[mb] = code; m_cs[mb] = w;
  endtask

  task automatic send(logic [28:0] id, logic [63:0] data, logic [6:0] ctl, bit chk_lock);
    logic [15:0] ts;
    logic [31:0] rd;
    int tgt;
    rx_idb2_stb = 1; ts = tb_cnt[15:0];
    @(negedge clk); rx_idb2_stb = 0;
    repeat (2) @(negedge clk);
    rx_id = id; rx_data = data; {rx_srr, rx_ide, rx_rtr, rx_dlc} = ctl;
    rx_frame_vld = 1;
    @(negedge clk); rx_frame_vld = 0;
    tgt = find_mb(id);
    if (chk_lock && tgt >= 0) begin
      cpu_read(mba(tgt, 0), rd);
      chk({31'd0, rd[7]}, 32'd1, "R11 lock bit during move-in");
      repeat (5) @(negedge clk);
    end else repeat (6) @(negedge clk);
    if (tgt >= 0) begin
      m_d0[tgt] = data[31:0]; m_d1[tgt] = data[63:32]; m_dv[tgt] = 1;
      m_cs[tgt] = {ts, 9'd0, ctl};
      m_code[tgt] = (m_code[tgt] == C_FULL) ? C_OVR : C_FULL;
      m_iflag[tgt] = 1'b1;
    end
  endtask

  task automatic verify_all(string tag);
    logic [31:0] rd;
    for (int i = 0; i < NMB; i++) begin
      cpu_read(mba(i, 0), rd); chk(rd, exp_cs(i), {tag, " R6 R7 R8 R11 word0"});
      cpu_read(mba(i, 1), rd); chk(rd, {3'b0, m_id[i]}, {tag, " R5 word1"});
      if (m_dv[i]) begin
        cpu_read(mba(i, 2), rd); chk(rd, m_d0[i], {tag, " R4 word2"});
        cpu_read(mba(i, 3), rd); chk(rd, m_d1[i], {tag, " R4 word3"});
      end
    end
    cpu_read(rega(0), rd); chk(rd, 32'(m_iflag), {tag, " R9 flags"});
    chk(32'(irq_o), 32'(m_iflag & m_imask), {tag, " R10 irq"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NMB; i++) begin
      m_code[i] = C_INA; m_id[i] = '0; m_cs[i] = '0; m_dv[i] = 0; m_d0[i] = '0; m_d1[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < NMB; i++) begin
      cpu_read(mba(i, 0), rd); chk(rd & 32'h0000_0F80, 32'd0, "R1 code inactive after reset");
      cpu_read(mba(i, 1), rd); chk(rd, 32'd0, "R1 id after reset");
    end
    cpu_read(rega(0), rd); chk(rd, 0, "R1 flags after reset");
    cpu_read(rega(1), rd); chk(rd, 0, "R1 mask after reset");
    chk(32'(irq_o), 0, "R1 irq after reset");

    // R12 register map: mask write/read back
    for (int i = 0; i < NMB; i++) arm(i, 29'h1555_5555 - 29'(i), C_INA, 32'h0);
    cpu_write(rega(1), 32'h0000_00A5); m_imask = 8'hA5;
    cpu_read(rega(1), rd); chk(rd, 32'hA5, "R12 mask register readback");

    // R2 inactive buffer with matching id drops the frame
    arm(0, 29'h55, C_INA, 32'h1234_0011);
    send(29'h55, 64'h1111_2222_3333_4444, 7'h08, 0);
    verify_all("R2 drop on inactive");

    // R3 priority, R8 overrun progression, R2 overrun ineligible
    arm(2, 29'h123, C_EMPTY, 32'h0);
    arm(5, 29'h123, C_EMPTY, 32'h0);
    send(29'h123, 64'hDEAD_BEEF_0BAD_F00D, 7'h68, 1);
    cpu_read(mba(2, 0), rd); chk(32'(rd[11:8]), 32'(C_FULL), "R3 lowest buffer becomes FULL");
    cpu_read(mba(5, 0), rd); chk(32'(rd[11:8]), 32'(C_EMPTY), "R3 higher buffer untouched");
    send(29'h123, 64'h0123_4567_89AB_CDEF, 7'h1F, 0);
    cpu_read(mba(2, 0), rd); chk(32'(rd[11:8]), 32'(C_OVR), "R8 FULL becomes OVERRUN");
    send(29'h123, 64'hFEDC_BA98_7654_3210, 7'h34, 0);
    cpu_read(mba(5, 0), rd); chk(32'(rd[11:8]), 32'(C_FULL), "R2 OVERRUN skipped, next buffer taken");
    verify_all("R3 priority");

    // R9 write-0 no effect, write-1 clears
    cpu_write(rega(0), 32'h0); @(negedge clk);
    cpu_read(rega(0), rd); chk(rd, 32'(m_iflag), "R9 write of 0 leaves flags");
    cpu_write(rega(0), 32'h04); m_iflag[2] = 0; @(negedge clk);
    cpu_read(rega(0), rd); chk(rd, 32'(m_iflag), "R9 write of 1 clears flag");

    // R10 mask gating
    cpu_write(rega(1), 32'h0); m_imask = '0; @(negedge clk);
    chk(32'(irq_o), 0, "R10 irq low with mask clear");
    cpu_write(rega(1), 32'h20); m_imask = 8'h20; @(negedge clk);
    chk(32'(irq_o), 32'h20, "R10 irq follows flag and mask");

    // Random mix
    for (int it = 0; it < 70; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        int mb;
        logic [3:0] cd;
        mb = $urandom % NMB;
        case ($urandom % 3) 0: cd = C_INA; 1: cd = C_EMPTY; default: cd = C_FULL; endcase
        arm(mb, pool[$urandom % 6], cd, $urandom);
        if ($urandom % 2) begin
          cpu_read(mba(mb, 0), rd); chk(rd, exp_cs(mb), "R12 word0 after CPU write");
        end
      end else if (op == 3) begin
        logic [7:0] mk, cl;
        mk = 8'($urandom); cl = 8'($urandom);
        cpu_write(rega(1), 32'(mk)); m_imask = mk;
        cpu_write(rega(0), 32'(cl)); m_iflag = m_iflag & ~cl;
        @(negedge clk);
        cpu_read(rega(0), rd); chk(rd, 32'(m_iflag), "R9 random clear");
        chk(32'(irq_o), 32'(m_iflag & m_imask), "R10 random mask");
      end else begin
        send(pool[$urandom % 6], {$urandom, $urandom}, 7'($urandom), ($urandom % 2) == 1);
        verify_all("R2 R3 random frame");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule